// File: doc/BRIEF.md
# DAC Input Register and Output Latch Controller

This block is the digital front end of a 12-bit voltage-output converter with an 8-bit parallel write port. A 2-bit address sends each write strobe to one of three places: the low byte of a 12-bit holding word, the upper nibble of that word, or a 5-bit control register. The fourth address is reserved, and a write to it changes nothing.

The holding word feeds an output code register. That register is either transparent, copying the holding word on every clock, or it keeps its value. It is transparent when the control register asks for it or when an active-low load pin, taken through a synchronizer, is low. Each mode output is the OR of a pin and a register bit:

- Settling speed is fast if the speed pin or the speed bit is set.
- Power-down is active if the active-low power pin is low or the power bit is set.

Power-down does not touch the stored codes, so the converter comes back on the code it held before. A 2-bit reference select goes straight from the control register to its output.

Top module: `dac_front_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the holding word, the output code and the control register to zero. After reset, `ref_sel`=0, and the speed and power-down outputs follow their pins alone.
- R2: A write with `wr_addr`=2'b00 loads `wr_data[7:0]` into bits 7..0 of the holding word and leaves bits 11..8 unchanged.
- R3: A write with `wr_addr`=2'b01 loads `wr_data[3:0]` into bits 11..8 of the holding word. `wr_data[7:4]` are ignored and bits 7..0 are unchanged.
- R4: A write with `wr_addr`=2'b11 loads the control register from these data bits:
  - bit 0: speed
  - bit 1: power-down
  - bit 2: latch-transparent
  - bits 4..3: reference select

  Bits 7..5 are ignored.
- R5: A write with `wr_addr`=2'b10 changes neither the holding word nor the control register.
- R6: While `wr_en` is low, nothing is written, whatever the address and data.
- R7: At every clock where the latch is open, `dac_code` takes the holding word as it stood before that edge. The latch is open when the latch-transparent bit is 1 or when the synchronized `load_n` is 0. The pin takes two flops to synchronize, so a change on it reaches the latch decision two edges later.
- R8: When the latch-transparent bit is 0 and the synchronized `load_n` is 1, `dac_code` keeps its value even while the holding word is written.
- R9: `powered_down` is 1 when the power-down bit is 1 or `pwr_on_n` is 0.
- R10: `fast_mode` is 1 when the speed bit is 1 or `speed_pin` is 1.
- R11: Entering or leaving power-down leaves `dac_code` and the holding word unchanged.
- R12: `ref_sel` equals control register bits 4..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, active high |
| wr_addr | input | 2 | Write destination select |
| wr_data | input | 8 | Write data byte |
| load_n | input | 1 | Asynchronous latch-load pin, active low |
| pwr_on_n | input | 1 | Power-down pin, active low |
| speed_pin | input | 1 | Fast-settling pin |
| dac_code | output | 12 | Registered converter code |
| powered_down | output | 1 | Combined power-down state |
| fast_mode | output | 1 | Combined settling-speed selection |
| ref_sel | output | 2 | Reference select field |

## Verification
Two functions can fall in the same clock: a write to the holding word and the copy of that word into the output code while the latch is open. The copy must take the word as it stood before the edge, and the new byte must appear one clock later. The bench provokes this by writing low and high bytes back to back with the transparent bit set. It provokes it again by lowering the load pin so that the synchronized level opens the latch just as a write lands. A behavioural model with its own two-entry pin history predicts the code for every clock, and the bench compares the code against it on every falling edge.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  typedef enum logic [1:0] {
    DEST_LOW  = 2'b00,
    DEST_HIGH = 2'b01,
    DEST_RSVD = 2'b10,
    DEST_CTRL = 2'b11
  } wr_dest_e;

  // field order follows the bit positions of the control byte
  typedef struct packed {
    logic [1:0] ref_sel;  // bits 4..3
    logic       transp;   // bit 2
    logic       pwr;      // bit 1
    logic       spd;      // bit 0
  } ctrl_t;

  function automatic ctrl_t ctrl_from_bits(input logic [4:0] b);
    return ctrl_t'(b);
  endfunction

  function automatic logic latch_open_f(input logic transp, input logic ldn_sync);
    return transp | ~ldn_sync;
  endfunction

  function automatic logic power_down_f(input logic pwr_bit, input logic pin_n);
    return pwr_bit | ~pin_n;
  endfunction

  function automatic logic fast_f(input logic spd_bit, input logic pin);
    return spd_bit | pin;
  endfunction
endpackage

// File: rtl/dac_write_regs.sv
module dac_write_regs
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] hold_word,
  output ctrl_t             ctrl,
  output logic              wr_low,
  output logic              wr_high,
  output logic              wr_ctrl
);
  localparam int HI_W = CODE_W - DATA_W;

  assign wr_low  = wr_en && (wr_dest_e'(wr_addr) == DEST_LOW);
  assign wr_high = wr_en && (wr_dest_e'(wr_addr) == DEST_HIGH);
  assign wr_ctrl = wr_en && (wr_dest_e'(wr_addr) == DEST_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
      ctrl      <= '0;
    end else begin
      if (wr_low)  hold_word[DATA_W-1:0]      <= wr_data;
      if (wr_high) hold_word[CODE_W-1:DATA_W] <= wr_data[HI_W-1:0];
      if (wr_ctrl) ctrl                       <= ctrl_from_bits(wr_data[4:0]);
    end
  end
endmodule

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_LEVEL;
        else     chain <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_LEVEL}};
        else     chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic [CODE_W-1:0] hold_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk) begin
    if (rst)         code_o <= '0;
    else if (open_i) code_o <= hold_i;
  end
endmodule

// File: rtl/dac_front_ctrl.sv
module dac_front_ctrl
  import dac_fe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_n,
  input  logic              pwr_on_n,
  input  logic              speed_pin,
  output logic [CODE_W-1:0] dac_code,
  output logic              powered_down,
  output logic              fast_mode,
  output logic [1:0]        ref_sel
);
  logic [CODE_W-1:0] hold_word;
  ctrl_t             ctrl;
  logic              wr_low, wr_high, wr_ctrl;
  logic              ldn_sync;
  logic              latch_open;

  dac_write_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hold_word(hold_word), .ctrl(ctrl),
    .wr_low(wr_low), .wr_high(wr_high), .wr_ctrl(wr_ctrl)
  );

  dac_pin_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_ldsync (
    .clk(clk), .rst(rst), .pin(load_n), .pin_sync(ldn_sync)
  );

  assign latch_open = latch_open_f(ctrl.transp, ldn_sync);

  dac_out_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst(rst), .open_i(latch_open), .hold_i(hold_word), .code_o(dac_code)
  );

  assign powered_down = power_down_f(ctrl.pwr, pwr_on_n);
  assign fast_mode    = fast_f(ctrl.spd, speed_pin);
  assign ref_sel      = ctrl.ref_sel;
endmodule

// File: rtl/dac_front_ctrl_chk.sv
module dac_front_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CODE_W-1:0] hold_word,
  input logic [CODE_W-1:0] dac_code,
  input logic              latch_open,
  input logic [1:0]        ref_sel
);
  p_low_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'b00) |=>
      (hold_word[DATA_W-1:0] == $past(wr_data) &&
       hold_word[CODE_W-1:DATA_W] == $past(hold_word[CODE_W-1:DATA_W])));

  p_high_nib_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'b01) |=>
      (hold_word[CODE_W-1:DATA_W] == $past(wr_data[CODE_W-DATA_W-1:0]) &&
       hold_word[DATA_W-1:0] == $past(hold_word[DATA_W-1:0])));

  p_ctrl_ref_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'b11) |=> (ref_sel == $past(wr_data[4:3])));

  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'b10) |=> ($stable(hold_word) && $stable(ref_sel)));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ($stable(hold_word) && $stable(ref_sel)));

  p_open_copy_r7: assert property (@(posedge clk) disable iff (rst)
    latch_open |=> (dac_code == $past(hold_word)));

  p_closed_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!latch_open) |=> $stable(dac_code));
endmodule

bind dac_front_ctrl dac_front_ctrl_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .hold_word(hold_word), .dac_code(dac_code), .latch_open(latch_open), .ref_sel(ref_sel)
);

// File: tb/dac_front_ctrl_bench.sv
`timescale 1ns/1ps
module dac_front_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'b00;
  logic [7:0]  wr_data = 8'h00;
  logic        load_n = 1'b1;
  logic        pwr_on_n = 1'b1;
  logic        speed_pin = 1'b0;
  logic [11:0] dac_code;
  logic        powered_down, fast_mode;
  logic [1:0]  ref_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dac_front_ctrl u_dac_front_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_n(load_n), .pwr_on_n(pwr_on_n), .speed_pin(speed_pin),
    .dac_code(dac_code), .powered_down(powered_down), .fast_mode(fast_mode),
    .ref_sel(ref_sel)
  );

  // behavioural reference: word, mode bits, pin history
  int m_word, m_code, m_spd, m_pwr, m_tr, m_ref;
  int pin_hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_word = 0; m_code = 0; m_spd = 0; m_pwr = 0; m_tr = 0; m_ref = 0;
      pin_hist = '{1, 1};
    end else begin
      if (m_tr == 1 || pin_hist[0] == 0) m_code = m_word;
      void'(pin_hist.pop_front());
      pin_hist.push_back(int'(load_n));
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_word = (m_word / 256) * 256 + int'(wr_data);
          2'd1: m_word = (int'(wr_data) % 16) * 256 + (m_word % 256);
          2'd3: begin
            m_spd = int'(wr_data[0]); m_pwr = int'(wr_data[1]);
            m_tr  = int'(wr_data[2]); m_ref = int'(wr_data[4:3]);
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7/R8 code vs model", int'(dac_code), m_code);
      check("R9 power-down vs model", int'(powered_down), (m_pwr == 1 || pwr_on_n == 1'b0) ? 1 : 0);
      check("R10 speed vs model", int'(fast_mode), (m_spd == 1 || speed_pin == 1'b1) ? 1 : 0);
      check("R12 ref vs model", int'(ref_sel), m_ref);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", wd, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 code after reset", int'(dac_code), 0);
    check("R1 ref after reset", int'(ref_sel), 0);
    check("R1 power after reset", int'(powered_down), 0);
    check("R1 speed after reset", int'(fast_mode), 0);

    // latch closed: writes must not reach the code
    wr(2'b00, 8'hA5);
    wr(2'b01, 8'hF3);
    step(2);
    check("R8 closed latch keeps code", int'(dac_code), 0);
    wr(2'b11, 8'h04);          // transparent
    step(2);
    check("R2 R3 low byte and nibble", int'(dac_code), 'h3A5);

    wr(2'b10, 8'hFF);          // reserved
    step(2);
    check("R5 reserved code", int'(dac_code), 'h3A5);
    check("R5 reserved ref", int'(ref_sel), 0);
    @(negedge clk); #1;
    wr_addr = 2'b11; wr_data = 8'hFF;  // strobe stays low
    step(2);
    check("R6 idle ref", int'(ref_sel), 0);
    check("R6 idle code", int'(dac_code), 'h3A5);

    wr(2'b11, 8'hFB);          // ref=3 pwr=1 spd=1 transparent=0, top bits junk
    step(1);
    check("R4 R12 ref field", int'(ref_sel), 3);
    check("R9 power bit", int'(powered_down), 1);
    check("R10 speed bit", int'(fast_mode), 1);

    wr(2'b00, 8'h11);          // held while powered down
    step(2);
    check("R8 held during write", int'(dac_code), 'h3A5);
    load_n = 1'b0;
    step(1);
    check("R7 sync delay", int'(dac_code), 'h3A5);
    step(2);
    check("R7 pin-opened copy", int'(dac_code), 'h311);
    load_n = 1'b1;
    step(3);

    wr(2'b11, 8'h00);          // release power-down
    step(1);
    check("R11 code after release", int'(dac_code), 'h311);
    check("R9 released", int'(powered_down), 0);
    pwr_on_n = 1'b0; speed_pin = 1'b1;
    step(1);
    check("R9 pin power-down", int'(powered_down), 1);
    check("R10 pin speed", int'(fast_mode), 1);
    check("R11 code under pin power-down", int'(dac_code), 'h311);
    pwr_on_n = 1'b1; speed_pin = 1'b0;

    // coincidence: writes land while latch open
    wr(2'b11, 8'h04);
    wr(2'b00, 8'h77);
    wr(2'b01, 8'h0C);
    step(2);
    check("R7 back-to-back writes", int'(dac_code), 'hC77);
    wr(2'b11, 8'h00);
    @(negedge clk); #1;
    load_n = 1'b0; wr_en = 1'b1; wr_addr = 2'b00; wr_data = 8'h5A;
    @(negedge clk); #1;
    wr_en = 1'b0;
    step(4);
    check("R7 pin open with write", int'(dac_code), 'hC5A);
    load_n = 1'b1;
    step(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule